// File: doc/BRIEF.md
# Clock Output Run/Stop and Rate Selection Controller

This block sits between the configuration registers of a clock generator and its bank of nineteen clock outputs: eight outputs in one wide group, three narrow groups of three, one reference output and one fixed-rate output. It turns the register bytes and a few board-level strap pins into the control signals those outputs need. These are a 5-bit frequency code for the synthesizer, a spread-spectrum enable, a global drive enable that can float every output, and a run/stop state for each output.

The strap pins are sampled once, a fixed number of system clocks after reset is released. The sampled values are then held and can be read back. A mode bit in the control byte decides what drives the frequency code and the spread enable. In one setting they follow the sampled straps. In the other they follow fields of the control byte.

Each divided clock passes through its own gate. The gate takes its run/stop decision only on a falling edge of that divided clock. A stopped output therefore parks low, and starting or stopping an output never produces a shortened pulse.

Top module: `clkctl_top`

## Requirements
- R1: The four strap pins and the spread pin are sampled exactly once, LATCH_DELAY system clocks after reset release. After that, `strap_readback` keeps the sampled select pins whatever the pins do later. Before sampling it reads 0.
- R2: When control bit 3 is 1, `freq_code` equals {control bit 2, control bits 7:4}, with bit 2 as the most significant bit. It follows one system clock after the control byte changes.
- R3: When control bit 3 is 0, `freq_code` equals {1'b0, sampled select pins}.
- R4: `spread_on` follows control bit 1 when control bit 3 is 1. It follows the sampled spread pin when control bit 3 is 0. The sampled spread value is 1 until the pins are sampled.
- R5: Control bit 0 = 1 drives every bit of `out_en` to 0, and control bit 0 = 0 drives every bit to 1. The change takes effect one system clock later.
- R6: The drive override has priority over the stop bits. With control bit 0 = 1, `out_en` is all zeros even when every stop bit requests run. The stop bits never alter `out_en`.
- R7: Output index to enable bit, where 1 means run: indices 0..7 use `cfg_run_wide` bits 0..7; 8..10 use `cfg_run_pair` bits 2..4; 11..13 use `cfg_run_pair` bits 5..7; 14..16 use `cfg_run_last` bits 5..7; 17 uses `cfg_run_misc` bit 6; 18 uses `cfg_run_misc` bit 7. All other bits of these bytes are ignored.
- R8: A running output reproduces its divided clock. A stopped output holds `gated_clk` low.
- R9: The run state of an output changes only on a falling edge of that output's divided clock, never while the clock is high.
- R10: During reset `gated_clk` and `out_en` are 0, `freq_code` is 0, `spread_on` is 1 and `strap_readback` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the control registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 8 | Control byte: rate code fields, source mode, spread, drive override |
| cfg_run_wide | input | 8 | Run bits for the eight-output group |
| cfg_run_pair | input | 8 | Run bits for two three-output groups |
| cfg_run_last | input | 8 | Run bits for the last three-output group |
| cfg_run_misc | input | 8 | Run bits for the reference and fixed-rate outputs |
| strap_sel | input | 4 | Select strap pins |
| strap_spread | input | 1 | Spread strap pin |
| div_clk | input | 19 | Divided clocks, one for each output |
| gated_clk | output | 19 | Gated output clocks |
| out_en | output | 19 | Output drive enables, 0 = high impedance |
| freq_code | output | 5 | Selected frequency code |
| spread_on | output | 1 | Selected spread-spectrum enable |
| strap_readback | output | 4 | Sampled select pins |

## Verification
The bench builds the block with LATCH_DELAY set to 8. This lets it see the readback at 0 before sampling, watch the single capture, and then move the pins to show that the held values do not change, all in a few dozen cycles. The nineteen divided clocks run at nineteen different half periods, all longer than one system clock. This places falling edges at many different offsets from the control updates, which exercises the falling-edge handover of every gate. Random control and run bytes cover both source modes and many stop patterns. Directed cases cover the drive override with every output running and the all-stopped case.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/100ps
package clkctl_pkg;

  localparam int unsigned WIDE_N   = 8;
  localparam int unsigned NARROW_N = 3;
  localparam int unsigned NARROW_GROUPS = 3;
  localparam int unsigned EXTRA_N  = 2;
  localparam int unsigned NUM_OUT  = WIDE_N + NARROW_N * NARROW_GROUPS + EXTRA_N;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned STRAP_W  = 4;

  // Rate code assembled from split fields of the control byte.
  function automatic logic [CODE_W-1:0] ctrl_rate_code(input logic [7:0] ctrl);
    return {ctrl[2], ctrl[7:4]};
  endfunction

  // Code presented while the straps are the source.
  function automatic logic [CODE_W-1:0] strap_rate_code(input logic [STRAP_W-1:0] s);
    return {1'b0, s};
  endfunction

  // Gather per-output run requests from the run bytes.
  function automatic logic [NUM_OUT-1:0] run_request_map(
    input logic [7:0] wide,
    input logic [7:0] pair,
    input logic [7:0] last,
    input logic [7:0] misc
  );
    return {misc[7], misc[6], last[7:5], pair[7:5], pair[4:2], wide};
  endfunction

endpackage

// File: rtl/clkctl_strap_latch.sv
`timescale 1ns/100ps
module clkctl_strap_latch #(
  parameter int unsigned LATCH_DELAY = 16,
  parameter int unsigned STRAP_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] pin_sel,
  input  logic               pin_spread,
  output logic [STRAP_W-1:0] held_sel,
  output logic               held_spread,
  output logic               captured
);

  localparam int unsigned CNT_W = (LATCH_DELAY < 2) ? 1 : $clog2(LATCH_DELAY);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATCH_DELAY - 1);

  logic [CNT_W-1:0] wait_cnt;
  logic             take_now;

  assign take_now = !captured && (wait_cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt    <= '0;
      captured    <= 1'b0;
      held_sel    <= '0;
      held_spread <= 1'b1;
    end else if (take_now) begin
      captured    <= 1'b1;
      held_sel    <= pin_sel;
      held_spread <= pin_spread;
    end else if (!captured) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/clkctl_mode_sel.sv
`timescale 1ns/100ps
module clkctl_mode_sel
  import clkctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          ctrl,
  input  logic [NUM_OUT-1:0]  run_req_in,
  input  logic [STRAP_W-1:0]  held_sel,
  input  logic                held_spread,
  output logic [CODE_W-1:0]   code_q,
  output logic                spread_q,
  output logic [NUM_OUT-1:0]  drive_q,
  output logic [NUM_OUT-1:0]  run_req_q
);

  logic use_regs;
  logic float_all;
  logic [CODE_W-1:0] code_next;
  logic spread_next;

  assign use_regs  = ctrl[3];
  assign float_all = ctrl[0];

  always_comb begin
    if (use_regs) begin
      code_next   = ctrl_rate_code(ctrl);
      spread_next = ctrl[1];
    end else begin
      code_next   = strap_rate_code(held_sel);
      spread_next = held_spread;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      spread_q  <= 1'b1;
      drive_q   <= '0;
      run_req_q <= '0;
    end else begin
      code_q    <= code_next;
      spread_q  <= spread_next;
      drive_q   <= {NUM_OUT{!float_all}};
      run_req_q <= run_req_in;
    end
  end

endmodule

// File: rtl/clkctl_gate.sv
`timescale 1ns/100ps
module clkctl_gate (
  input  logic div_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic run_state,
  output logic gated
);

  always_ff @(negedge div_clk or negedge rst_n) begin
    if (!rst_n) run_state <= 1'b0;
    else        run_state <= run_req;
  end

  assign gated = div_clk & run_state;

endmodule

// File: rtl/clkctl_top.sv
`timescale 1ns/100ps
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int unsigned LATCH_DELAY = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          cfg_ctrl,
  input  logic [7:0]          cfg_run_wide,
  input  logic [7:0]          cfg_run_pair,
  input  logic [7:0]          cfg_run_last,
  input  logic [7:0]          cfg_run_misc,
  input  logic [3:0]          strap_sel,
  input  logic                strap_spread,
  input  logic [18:0]         div_clk,
  output logic [18:0]         gated_clk,
  output logic [18:0]         out_en,
  output logic [4:0]          freq_code,
  output logic                spread_on,
  output logic [3:0]          strap_readback
);

  logic [STRAP_W-1:0] held_sel;
  logic               held_spread;
  logic               strap_done;
  logic [NUM_OUT-1:0] run_req_comb;
  logic [NUM_OUT-1:0] run_req_q;
  logic [NUM_OUT-1:0] run_state;
  logic               unused_run_bits;

  assign unused_run_bits = ^{cfg_run_pair[1:0], cfg_run_last[4:0], cfg_run_misc[5:0]};

  clkctl_strap_latch #(
    .LATCH_DELAY (LATCH_DELAY),
    .STRAP_W     (STRAP_W)
  ) u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_sel     (strap_sel),
    .pin_spread  (strap_spread),
    .held_sel    (held_sel),
    .held_spread (held_spread),
    .captured    (strap_done)
  );

  assign run_req_comb = run_request_map(cfg_run_wide, cfg_run_pair, cfg_run_last, cfg_run_misc);

  clkctl_mode_sel u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (cfg_ctrl),
    .run_req_in  (run_req_comb),
    .held_sel    (held_sel),
    .held_spread (held_spread),
    .code_q      (freq_code),
    .spread_q    (spread_on),
    .drive_q     (out_en),
    .run_req_q   (run_req_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    clkctl_gate u_gate (
      .div_clk   (div_clk[g]),
      .rst_n     (rst_n),
      .run_req   (run_req_q[g]),
      .run_state (run_state[g]),
      .gated     (gated_clk[g])
    );
  end

  assign strap_readback = held_sel;

endmodule

// File: rtl/clkctl_chk.sv
`timescale 1ns/100ps
module clkctl_chk
  import clkctl_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          cfg_ctrl,
  input logic [7:0]          cfg_run_wide,
  input logic [CODE_W-1:0]   freq_code,
  input logic                spread_on,
  input logic [NUM_OUT-1:0]  out_en,
  input logic [STRAP_W-1:0]  strap_readback,
  input logic                strap_done,
  input logic [NUM_OUT-1:0]  div_clk,
  input logic [NUM_OUT-1:0]  run_state
);

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(strap_readback));

  // R2
  reg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ctrl[3] |=> freq_code == {$past(cfg_ctrl[2]), $past(cfg_ctrl[7:4])});

  // R3
  strap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctrl[3] |=> freq_code == {1'b0, $past(strap_readback)});

  // R4
  reg_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ctrl[3] |=> spread_on == $past(cfg_ctrl[1]));

  // R5
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ctrl[0] |=> out_en == '0);

  // R6
  drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ctrl[0] && cfg_run_wide == 8'h00) |=> &out_en);

  // R9: sampled at system edges; divided clock phases are longer than one system period
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_glitch
    no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_clk[g] && $past(div_clk[g])) |-> $stable(run_state[g]));
  end

endmodule

bind clkctl_top clkctl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_ctrl       (cfg_ctrl),
  .cfg_run_wide   (cfg_run_wide),
  .freq_code      (freq_code),
  .spread_on      (spread_on),
  .out_en         (out_en),
  .strap_readback (strap_readback),
  .strap_done     (strap_done),
  .div_clk        (div_clk),
  .run_state      (run_state)
);

// File: tb/test_clkctl_top.sv
`timescale 1ns/100ps
module test_clkctl_top;

  localparam int N = 19;
  localparam int DELAY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] c_ctrl = 8'h00, c_wide = 8'hFF, c_pair = 8'hFF, c_last = 8'hFF, c_misc = 8'hFF;
  logic [3:0] s_sel = 4'b1011;
  logic s_spread = 1'b0;
  logic [N-1:0] dclk;
  logic [N-1:0] gclk, oen;
  logic [4:0] fcode;
  logic spr;
  logic [3:0] rb;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  clkctl_top #(.LATCH_DELAY(DELAY)) i_clkctl_top (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(c_ctrl), .cfg_run_wide(c_wide),
    .cfg_run_pair(c_pair), .cfg_run_last(c_last), .cfg_run_misc(c_misc),
    .strap_sel(s_sel), .strap_spread(s_spread), .div_clk(dclk),
    .gated_clk(gclk), .out_en(oen), .freq_code(fcode), .spread_on(spr),
    .strap_readback(rb)
  );

  always #5 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_div
    initial begin
      dclk[i] = 1'b0;
      #(3 + i);
      forever #(11 + 2 * i) dclk[i] = ~dclk[i];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected run mask, built index by index from the R7 table
  function automatic logic [N-1:0] exp_run(input logic [7:0] w, p, l, m);
    logic [N-1:0] r;
    for (int i = 0; i < 8; i++) r[i] = w[i];
    for (int k = 0; k < 3; k++) begin
      r[8 + k]  = p[2 + k];
      r[11 + k] = p[5 + k];
      r[14 + k] = l[5 + k];
    end
    r[17] = m[6];
    r[18] = m[7];
    return r;
  endfunction

  function automatic logic [4:0] exp_code(input logic [7:0] c, input logic [3:0] straps);
    if (c[3]) return {c[2], c[7], c[6], c[5], c[4]};
    return {1'b0, straps};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R8: sample gated outputs at half-ns offsets, away from any divided-clock edge
  task automatic check_gating(input string tag, input logic [N-1:0] run);
    #250.5;
    for (int j = 0; j < 6; j++) begin
      chk(tag, 32'(gclk), 32'(dclk & run));
      #13;
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd5150));
    // R10 reset state
    #22.5;
    chk("R10 gated", 32'(gclk), 32'd0);
    chk("R10 out_en", 32'(oen), 32'd0);
    chk("R10 freq_code", 32'(fcode), 32'd0);
    chk("R10 spread_on", 32'(spr), 32'd1);
    chk("R10 readback", 32'(rb), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cycles(3);
    chk("R1 before sample", 32'(rb), 32'd0);
    chk("R4 spread default", 32'(spr), 32'd1);
    cycles(DELAY + 2);
    chk("R1 sampled", 32'(rb), 32'hB);
    s_sel = 4'b0100;
    s_spread = 1'b1;
    cycles(5);
    chk("R1 held", 32'(rb), 32'hB);
    chk("R3 strap code", 32'(fcode), 32'(exp_code(8'h00, 4'hB)));
    chk("R4 strap spread", 32'(spr), 32'd0);
    chk("R5 drive on", 32'(oen), 32'h7FFFF);

    for (int it = 0; it < 24; it++) begin
      logic [N-1:0] er;
      c_ctrl = 8'($urandom);
      c_wide = 8'($urandom);
      c_pair = 8'($urandom);
      c_last = 8'($urandom);
      c_misc = 8'($urandom);
      cycles(2);
      chk("R2 R3 freq_code", 32'(fcode), 32'(exp_code(c_ctrl, 4'hB)));
      chk("R4 spread_on", 32'(spr), 32'(c_ctrl[3] ? c_ctrl[1] : 1'b0));
      chk("R5 R6 out_en", 32'(oen), c_ctrl[0] ? 32'd0 : 32'h7FFFF);
      er = exp_run(c_wide, c_pair, c_last, c_misc);
      check_gating("R7 R8 R9 gating", er);
    end

    // R6: override wins even with every output requested to run
    c_ctrl = 8'h01; c_wide = 8'hFF; c_pair = 8'hFF; c_last = 8'hFF; c_misc = 8'hFF;
    cycles(2);
    chk("R6 override priority", 32'(oen), 32'd0);
    // R7: only the ignored bits set, so every output must stop
    c_ctrl = 8'h00; c_wide = 8'h00; c_pair = 8'h03; c_last = 8'h1F; c_misc = 8'h3F;
    cycles(2);
    chk("R6 stops leave drive", 32'(oen), 32'h7FFFF);
    check_gating("R7 ignored bits", '0);
    // R8: all run again
    c_wide = 8'hFF; c_pair = 8'hFC; c_last = 8'hE0; c_misc = 8'hC0;
    check_gating("R8 all run", '1);
    // R2: register code with top bit from bit 2 only
    c_ctrl = 8'h0C;
    cycles(2);
    chk("R2 split field", 32'(fcode), 32'h10);
    c_ctrl = 8'hFA;
    cycles(2);
    chk("R2 low field", 32'(fcode), 32'h0F);
    chk("R4 reg spread", 32'(spr), 32'd1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule